// File: doc/BRIEF.md
# Tag CAM with LRU Victim Selection

This block is a sixteen-entry content-addressable tag store. Every entry holds a 32-bit tag, a valid flag and four state bits that belong to software. A lookup compares one key against all valid tags at once. One clock later it returns a 9-bit result word with a strobe. On a hit the word carries the hit flag, the index of the matching entry and that entry's state bits. On a miss it carries the index of the least recently used entry, which software can take as the victim for its next write.

Software fills entries through a write port that loads tag, state and valid together. A second port rewrites only the state bits of one entry. A clear command invalidates everything and restores a fixed recency order. Recency is tracked across all entries and changes only on hits and full writes. State bits play no part in matching or in replacement.

Top module: `tag_cam`

## Requirements
- R1: `res_vld` is high exactly in the cycle after a cycle with `lk_req` high. While `res_vld` is low, `res_word` is all zeros.
- R2: The result word is laid out as follows: bit 8 is the hit flag, bits 7:4 are the state field and bits 3:0 are the entry index.
- R3: A lookup hits when a valid entry's tag equals the key. An invalid entry never hits. When several valid entries match, the lowest-numbered one is reported, together with its state bits.
- R4: On a miss, bit 8 is 0, the state field is 0 and the index is the least recently used entry.
- R5: A lookup hit or a full write makes that entry the most recently used. A miss and a state-only write leave the recency order unchanged.
- R6: A state-only write changes the state bits of one entry and nothing else. State values never affect which entry hits or which entry is the victim.
- R7: Reset and clear both invalidate every entry and set the recency order so that entry 0 is the oldest and entry 15 is the newest. A lookup right after either returns the word 0x000.
- R8: In a cycle with several operations, the lookup sees the contents from before that cycle's updates. Clear overrides any write in the same cycle. When a hit and a full write fall in one cycle, the written entry becomes newest and the hit entry becomes second newest. When a full write and a state-only write target the same entry, the full write's state value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_key | input | 32 | Lookup key |
| wr_en | input | 1 | Full entry write |
| wr_idx | input | 4 | Entry written by the full write |
| wr_tag | input | 32 | Tag for the full write |
| wr_state | input | 4 | State bits for the full write |
| st_en | input | 1 | State-only write |
| st_idx | input | 4 | Entry targeted by the state-only write |
| st_val | input | 4 | New state bits |
| clr | input | 1 | Invalidate all entries and reset recency |
| res_vld | output | 1 | Result strobe, one cycle after a lookup |
| res_word | output | 9 | Result: hit, state, index |

## Verification
The assertions check on every cycle that the strobe follows a lookup by one clock, that the result word is zero when idle, and that a miss carries a zero state field. They also cover three pairs of operations in consecutive cycles: a write followed by a lookup of the same tag must hit, a write followed by a missing lookup must not name the entry just written, and a clear followed by a lookup must return zero. The full recency order over sixteen entries is checked only by the bench's reference model. The same holds for lowest-index choice among duplicates, for state-only writes leaving the order alone, and for the same-cycle priorities. The model tracks the order as a queue and compares the result word on every clock.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int CAM_N  = 16;
    localparam int CAM_KW = 32;
    localparam int CAM_SW = 4;
    localparam int CAM_IW = $clog2(CAM_N);
    localparam int CAM_RW = 1 + CAM_SW + CAM_IW;

    typedef struct packed {
        logic              hit;
        logic [CAM_SW-1:0] st;
        logic [CAM_IW-1:0] idx;
    } cam_res_t;

    typedef struct packed {
        logic              en;
        logic [CAM_IW-1:0] idx;
    } touch_t;

    function automatic cam_res_t make_hit(input logic [CAM_SW-1:0] st,
                                          input logic [CAM_IW-1:0] idx);
        cam_res_t r;
        r.hit = 1'b1;
        r.st  = st;
        r.idx = idx;
        return r;
    endfunction

    function automatic cam_res_t make_miss(input logic [CAM_IW-1:0] victim);
        cam_res_t r;
        r.hit = 1'b0;
        r.st  = '0;
        r.idx = victim;
        return r;
    endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
#(
    parameter int N  = CAM_N,
    parameter int KW = CAM_KW,
    parameter int SW = CAM_SW,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [KW-1:0]        wr_tag,
    input  logic [SW-1:0]        wr_state,
    input  logic                 st_en,
    input  logic [IW-1:0]        st_idx,
    input  logic [SW-1:0]        st_val,
    output logic [N-1:0][KW-1:0] tags,
    output logic [N-1:0][SW-1:0] states,
    output logic [N-1:0]         valid
);

    logic [N-1:0][KW-1:0] tag_q;
    logic [N-1:0][SW-1:0] st_q;
    logic [N-1:0]         vld_q;
    logic                 st_blocked;

    assign st_blocked = wr_en && (wr_idx == st_idx);

    always_ff @(posedge clk) begin
        if (wr_en && !rst && !clr) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld_q <= '0;
            st_q  <= '0;
        end else begin
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
                st_q[wr_idx]  <= wr_state;
            end
            if (st_en && !st_blocked) begin
                st_q[st_idx] <= st_val;
            end
        end
    end

    assign tags   = tag_q;
    assign states = st_q;
    assign valid  = vld_q;

endmodule

// File: rtl/cam_match.sv
module cam_match
    import cam_pkg::*;
#(
    parameter int N  = CAM_N,
    parameter int KW = CAM_KW,
    localparam int IW = $clog2(N)
) (
    input  logic [KW-1:0]        key,
    input  logic [N-1:0][KW-1:0] tags,
    input  logic [N-1:0]         valid,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx
);

    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/cam_lru.sv
module cam_lru
    import cam_pkg::*;
#(
    parameter int N = CAM_N,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ta_en,
    input  logic [IW-1:0] ta_idx,
    input  logic          tb_en,
    input  logic [IW-1:0] tb_idx,
    output logic [IW-1:0] victim
);

    // older_q[i][j] = 1 means entry i was used less recently than entry j
    logic [N-1:0][N-1:0] older_q, after_a, older_d, init_m;
    logic [N-1:0]        is_oldest;

    function automatic logic [N-1:0][N-1:0] touch(input logic [N-1:0][N-1:0] m,
                                                  input logic [IW-1:0] k);
        logic [N-1:0][N-1:0] r;
        r = m;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (i == int'(k))      r[i][j] = 1'b0;
                else if (j == int'(k)) r[i][j] = 1'b1;
            end
        end
        return r;
    endfunction

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            assign init_m[gi][gj] = (gi < gj) ? 1'b1 : 1'b0;
        end
        logic [N-1:0] self_m;
        assign self_m        = N'(1) << gi;
        assign is_oldest[gi] = &(older_q[gi] | self_m);
    end

    always_comb begin
        after_a = ta_en ? touch(older_q, ta_idx) : older_q;
        older_d = tb_en ? touch(after_a, tb_idx) : after_a;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) older_q <= init_m;
        else            older_q <= older_d;
    end

    always_comb begin
        victim = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (is_oldest[i]) victim = IW'(i);
        end
    end

endmodule

// File: rtl/tag_cam.sv
module tag_cam
    import cam_pkg::*;
#(
    parameter int N_ENT = CAM_N,
    parameter int KEY_W = CAM_KW,
    parameter int ST_W  = CAM_SW,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int RES_W = 1 + ST_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [KEY_W-1:0] lk_key,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_tag,
    input  logic [ST_W-1:0]  wr_state,
    input  logic             st_en,
    input  logic [IDX_W-1:0] st_idx,
    input  logic [ST_W-1:0]  st_val,
    input  logic             clr,
    output logic             res_vld,
    output logic [RES_W-1:0] res_word
);

    logic [N_ENT-1:0][KEY_W-1:0] tags;
    logic [N_ENT-1:0][ST_W-1:0]  states;
    logic [N_ENT-1:0]            valid;
    logic                        hit;
    logic [IDX_W-1:0]            hit_idx, victim;
    touch_t                      t_hit, t_wr;
    cam_res_t                    res_d, res_q;
    logic                        vld_q;

    cam_store #(.N(N_ENT), .KW(KEY_W), .SW(ST_W)) u_store (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state),
        .st_en(st_en), .st_idx(st_idx), .st_val(st_val),
        .tags(tags), .states(states), .valid(valid)
    );

    cam_match #(.N(N_ENT), .KW(KEY_W)) u_match (
        .key(lk_key), .tags(tags), .valid(valid),
        .hit(hit), .hit_idx(hit_idx)
    );

    always_comb begin
        t_hit.en  = lk_req && hit;
        t_hit.idx = hit_idx;
        t_wr.en   = wr_en;
        t_wr.idx  = wr_idx;
    end

    cam_lru #(.N(N_ENT)) u_lru (
        .clk(clk), .rst(rst), .clr(clr),
        .ta_en(t_hit.en), .ta_idx(t_hit.idx),
        .tb_en(t_wr.en), .tb_idx(t_wr.idx),
        .victim(victim)
    );

    always_comb begin
        res_d = '0;
        if (lk_req) begin
            if (hit) res_d = make_hit(states[hit_idx], hit_idx);
            else     res_d = make_miss(victim);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            res_q <= res_d;
            vld_q <= lk_req;
        end
    end

    assign res_vld  = vld_q;
    assign res_word = res_q;

endmodule

// File: rtl/tag_cam_chk.sv
module tag_cam_chk
    import cam_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_req,
    input logic [CAM_KW-1:0] lk_key,
    input logic              wr_en,
    input logic [CAM_IW-1:0] wr_idx,
    input logic [CAM_KW-1:0] wr_tag,
    input logic              clr,
    input logic              res_vld,
    input logic [CAM_RW-1:0] res_word
);

    p_strobe_after_req_r1: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> res_vld);

    p_no_strobe_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !res_vld);

    p_idle_word_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> (res_word == '0));

    p_miss_state_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_word[8]) |-> (res_word[7:4] == '0));

    p_write_then_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) ##1 (lk_req && lk_key == $past(wr_tag)) |=> res_word[8]);

    p_fresh_not_victim_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) ##1 lk_req |=>
            (res_word[8] || res_word[3:0] != $past(wr_idx, 2)));

    p_clear_then_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clr ##1 lk_req |=> (res_word == '0));

endmodule

bind tag_cam tag_cam_chk u_chk (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_key(lk_key),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .clr(clr),
    .res_vld(res_vld), .res_word(res_word)
);

// File: tb/sim_tag_cam.sv
`timescale 1ns/1ps
module sim_tag_cam;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_key = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_tag = '0;
    logic [3:0]  wr_state = '0;
    logic        st_en = 1'b0;
    logic [3:0]  st_idx = '0;
    logic [3:0]  st_val = '0;
    logic        clr = 1'b0;
    logic        res_vld;
    logic [8:0]  res_word;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    string cur = "R7";

    logic [31:0] m_tag [16];
    logic [3:0]  m_st  [16];
    bit          m_vld [16];
    int          m_q[$];

    always #2 clk = ~clk;

    tag_cam u0 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_key(lk_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state),
        .st_en(st_en), .st_idx(st_idx), .st_val(st_val), .clr(clr),
        .res_vld(res_vld), .res_word(res_word)
    );

    task automatic model_clear();
        m_q.delete();
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 0;
            m_st[i]  = '0;
            m_tag[i] = '0;
            m_q.push_back(i);
        end
    endtask

    task automatic model_touch(input int k);
        for (int i = 0; i < m_q.size(); i++) begin
            if (m_q[i] == k) begin
                m_q.delete(i);
                break;
            end
        end
        m_q.push_back(k);
    endtask

    task automatic check(input bit ev, input logic [8:0] ew);
        n_chk++;
        if (res_vld !== ev || res_word !== ew) begin
            n_err++;
            $display("FAIL %s: vld=%0b word=%03h expected vld=%0b word=%03h",
                     cur, res_vld, res_word, ev, ew);
        end
    endtask

    task automatic cyc(input bit lk, input logic [31:0] key,
                       input bit w, input logic [3:0] wi, input logic [31:0] wt,
                       input logic [3:0] ws,
                       input bit s, input logic [3:0] si, input logic [3:0] sv,
                       input bit c);
        int          h;
        bit          ev;
        logic [8:0]  ew;
        @(negedge clk);
        lk_req = lk; lk_key = key;
        wr_en = w; wr_idx = wi; wr_tag = wt; wr_state = ws;
        st_en = s; st_idx = si; st_val = sv; clr = c;
        h = -1;
        for (int i = 15; i >= 0; i--) if (m_vld[i] && m_tag[i] == key) h = i;
        ev = lk;
        ew = '0;
        if (lk) ew = (h >= 0) ? {1'b1, m_st[h], 4'(h)} : {1'b0, 4'h0, 4'(m_q[0])};
        @(posedge clk);
        #1;
        check(ev, ew);
        if (c) model_clear();
        else begin
            if (lk && h >= 0) model_touch(h);
            if (w) begin
                m_tag[wi] = wt; m_st[wi] = ws; m_vld[wi] = 1;
                model_touch(int'(wi));
            end
            if (s && !(w && wi == si)) m_st[si] = sv;
        end
    endtask

    task automatic look(input logic [31:0] key);
        cyc(1, key, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input logic [3:0] i, input logic [31:0] t, input logic [3:0] s);
        cyc(0, 0, 1, i, t, s, 0, 0, 0, 0);
    endtask

    function automatic logic [31:0] tg(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0001_0111;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7 reset state and R1 idle
        cur = "R7"; idle(); look(32'hDEAD_BEEF); look(32'h0);
        cur = "R1"; idle(); look(32'h5); look(32'h6); idle(); idle();
        // R2 R3 fill and hit
        cur = "R2";
        for (int i = 0; i < 16; i++) wr(4'(i), tg(i), 4'(i ^ 5));
        cur = "R3";
        for (int i = 15; i >= 0; i -= 3) look(tg(i));
        // R4 miss reports victim
        cur = "R4";
        look(32'hFFFF_0000); look(32'hABCD_0001);
        // R5 hits reorder, misses do not
        cur = "R5";
        look(tg(1)); look(tg(2)); look(32'h0BAD_0000); look(32'h0BAD_0000);
        wr(4'd4, tg(4), 4'h9); look(32'h0BAD_0001);
        // R6 state writes
        cur = "R6";
        cyc(0, 0, 0, 0, 0, 0, 1, 4'd5, 4'hF, 0);
        look(32'h0BAD_0002);
        look(tg(5));
        cyc(0, 0, 0, 0, 0, 0, 1, 4'd6, 4'h0, 0);
        look(32'h0BAD_0003); look(tg(6));
        // R3 duplicates: lowest index wins
        cur = "R3";
        wr(4'd12, tg(3), 4'hA); look(tg(3));
        wr(4'd3, 32'h7777_7777, 4'h1); look(tg(3)); look(32'h7777_7777);
        // R8 same-cycle combinations
        cur = "R8";
        cyc(1, tg(7), 1, 4'd7, 32'h8888_0000, 4'h2, 0, 0, 0, 0);
        look(tg(7)); look(32'h8888_0000);
        cyc(1, tg(8), 1, 4'd9, 32'h9999_0000, 4'h3, 0, 0, 0, 0);
        look(32'h0BAD_0004);
        cyc(0, 0, 1, 4'd10, 32'hAAAA_0000, 4'h4, 1, 4'd10, 4'hC, 0);
        look(32'hAAAA_0000);
        cyc(1, tg(11), 1, 4'd11, 32'h1, 4'h1, 0, 0, 0, 1);
        look(tg(11)); look(32'h1);
        // R7 clear
        cur = "R7";
        wr(4'd0, 32'h42, 4'h7); wr(4'd1, 32'h43, 4'h8);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        look(32'h42); look(32'h43); look(32'h0);
        // random mix
        cur = "R5 random";
        for (int n = 0; n < 3000; n++) begin
            bit          lk, w, s, c;
            logic [31:0] key, t;
            lk  = ($urandom % 10) < 7;
            w   = ($urandom % 10) < 3;
            s   = ($urandom % 10) < 2;
            c   = ($urandom % 200) == 0;
            key = 32'h5000 + 32'($urandom % 24);
            t   = 32'h5000 + 32'($urandom % 24);
            cyc(lk, key, w, 4'($urandom), t, 4'($urandom),
                s, 4'($urandom), 4'($urandom), c);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule